// File: doc/BRIEF.md
# Indirect Packet Buffer Data Port

This block is the host's window into a packet buffer that is split into fixed-size slots. The host picks a slot with a slot-number register. It then loads a pointer register, which holds a byte offset inside that slot and three mode flags: read direction, receive-side slot and auto-advance. After that, the host moves 16-bit words through a single data register. Each write goes into a short queue and drains into the buffer one word per cycle. Each read is fetched ahead of time, so the data register already holds the word before the host asks for it.

The block also checks the layout of a transmit frame that the host has built in a slot. That layout is a status word, a length word, the payload and a closing control word. When the host commits the frame, the block reports whether the layout holds together. On the receive side, when a frame's length word is read back, only its valid low bits are passed through.

Top module: `pkt_data_port`

## Requirements
- R1: After reset, `dat_valid`, `ptr_busy` and `chk_done` are all 0.
- R2: The pointer word is laid out as follows. Bits [10:0] hold the byte offset, and bit 0 is ignored because access is word aligned. Bit 13 selects read direction, bit 14 enables auto-advance and bit 15 selects the receive-side slot. With bit 15 clear, the slot used is the one held in the slot-number register. With bit 15 set, the slot used is `rx_pnum`.
- R3: A data write in write direction enters the write queue. `ptr_busy` is 1 while the queue holds any word. Once drained, the written word can be read back at the offset where it was written.
- R4: A pointer load presented while `ptr_busy` is 1 is ignored: the offset and the flags keep their values.
- R5: With auto-advance set, each accepted data write or read moves the offset forward by 2. An offset of 2046 wraps to 0 inside the same slot. With auto-advance clear, the offset does not move.
- R6: After an accepted read-direction pointer load, `dat_valid` is 0 at the first clock edge and becomes 1 at the second edge, holding the word at the offset. A read strobe accepted while `dat_valid` is 1 drops `dat_valid` for one cycle. The next word is then presented.
- R7: `dat_be[0]` enables a write of bits [7:0] and `dat_be[1]` enables a write of bits [15:8]. A lane that is not enabled keeps its stored value.
- R8: A read through the receive-side slot at byte offset 2 returns bits [15:11] as 0. The same word read through the transmit side comes back whole.
- R9: One cycle after `tx_commit`, `chk_done` pulses for exactly one cycle. `chk_ok` is then 1 only if all of the following hold for the last length word written at byte offset 2, called L: 66 ≤ L ≤ 2048; the last word written is at byte offset (L−2) rounded down to even; and bit 13 of that word equals bit 0 of L.
- R10: A data write while read direction is selected is dropped and does not move the offset. A read strobe while `dat_valid` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pnum_we | input | 1 | Load slot-number register |
| pnum_in | input | SLOT_W | Slot number to load |
| rx_pnum | input | SLOT_W | Slot presented by the receive side |
| ptr_we | input | 1 | Load pointer register |
| ptr_in | input | 16 | Pointer word (offset and flags) |
| dat_we | input | 1 | Data write strobe |
| dat_be | input | 2 | Byte-lane enables for the write |
| dat_in | input | 16 | Write data |
| dat_re | input | 1 | Data read strobe (consumes the presented word) |
| dat_out | output | 16 | Prefetched read word |
| dat_valid | output | 1 | `dat_out` holds a fetched word |
| ptr_busy | output | 1 | Write queue not empty; pointer loads refused |
| tx_commit | input | 1 | Request a transmit-layout check |
| chk_done | output | 1 | Check result is valid (one-cycle pulse) |
| chk_ok | output | 1 | Transmit layout is consistent |

## Verification
The main data path is exercised with several access patterns:
- **Auto-advance bursts.** Separate ordering errors from addressing errors.
- **A fixed-offset pointer.** Shows that the offset really holds still.
- **A burst that crosses offset 2046.** Shows whether the wrap stays inside the slot or leaks into the next one.
- **Partial byte-lane writes.** Expose lane swaps.
- **The same word read through the receive side and the transmit side.** Isolates the length mask from a slot-selection error.

The layout checker is given a minimum padded even frame, an odd frame carrying its last byte in the control word, a short length, and control words whose odd flag disagrees with the length in either direction. This separates the bound test, the position test and the parity test from one another.

// File: rtl/pkt_data_port.sv
module pkt_data_port #(
  parameter int SLOT_W  = 1,
  parameter int OFF_W   = 11,
  parameter int FDEPTH  = 4,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pnum_we,
  input  logic [SLOT_W-1:0] pnum_in,
  input  logic [SLOT_W-1:0] rx_pnum,
  input  logic              ptr_we,
  input  logic [15:0]       ptr_in,
  input  logic              dat_we,
  input  logic [1:0]        dat_be,
  input  logic [15:0]       dat_in,
  input  logic              dat_re,
  output logic [15:0]       dat_out,
  output logic              dat_valid,
  output logic              ptr_busy,
  input  logic              tx_commit,
  output logic              chk_done,
  output logic              chk_ok
);
  localparam int WI_W       = OFF_W - 1;
  localparam int AW         = SLOT_W + WI_W;
  localparam int WORDS      = 1 << AW;
  localparam int SLOT_BYTES = 1 << OFF_W;
  localparam int FPW        = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int B_RD = 13;
  localparam int B_AI = 14;
  localparam int B_RX = 15;

  logic [15:0]       mem [WORDS];
  logic [SLOT_W-1:0] pnum_q;
  logic [OFF_W-1:0]  off_q;
  logic              rd_q, ai_q, rx_q, pf_pend;
  logic [15:0]       dat_q;

  logic [AW-1:0]     f_addr [FDEPTH];
  logic [1:0]        f_be   [FDEPTH];
  logic [15:0]       f_dat  [FDEPTH];
  logic [FPW-1:0]    f_wp, f_rp;
  logic [FPW:0]      f_cnt;

  logic [15:0]       len_q;
  logic [WI_W-1:0]   last_wi;
  logic              last_b13;

  logic unused_ptr_bits;
  assign unused_ptr_bits = ^{ptr_in[B_RD-1:OFF_W], ptr_in[0]};

  wire [SLOT_W-1:0] cur_slot = rx_q ? rx_pnum : pnum_q;
  wire [AW-1:0]     cur_addr = {cur_slot, off_q[OFF_W-1:1]};
  wire              ptr_take = ptr_we && f_cnt == '0;
  wire              push     = dat_we && !rd_q && f_cnt != (FPW+1)'(FDEPTH);
  wire              pop      = f_cnt != '0;
  wire              consume  = dat_re && dat_valid && rd_q;
  wire              len_word = rx_q && off_q[OFF_W-1:1] == WI_W'(1);
  wire [AW-1:0]     h_addr   = f_addr[f_rp];
  wire [WI_W-1:0]   h_wi     = h_addr[WI_W-1:0];
  wire [WI_W-1:0]   ctl_wi   = WI_W'(len_q[OFF_W-1:1] - 1'b1);
  wire              frame_ok = len_q >= 16'(MIN_LEN) && {16'd0, len_q} <= 32'(SLOT_BYTES)
                               && last_wi == ctl_wi && last_b13 == len_q[0];

  assign ptr_busy = pop;
  assign dat_out  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnum_q <= '0;
    end else if (pnum_we) begin
      pnum_q <= pnum_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      rd_q  <= 1'b0;
      ai_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else if (ptr_take) begin
      off_q <= {ptr_in[OFF_W-1:1], 1'b0};
      rd_q  <= ptr_in[B_RD];
      ai_q  <= ptr_in[B_AI];
      rx_q  <= ptr_in[B_RX];
    end else if (ai_q && (push || consume)) begin
      off_q <= off_q + OFF_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_wp  <= '0;
      f_rp  <= '0;
      f_cnt <= '0;
    end else begin
      if (push) f_wp <= (f_wp == FPW'(FDEPTH-1)) ? '0 : f_wp + 1'b1;
      if (pop)  f_rp <= (f_rp == FPW'(FDEPTH-1)) ? '0 : f_rp + 1'b1;
      f_cnt <= f_cnt + (FPW+1)'(push) - (FPW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_addr[f_wp] <= cur_addr;
      f_be[f_wp]   <= dat_be;
      f_dat[f_wp]  <= dat_in;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      if (f_be[f_rp][0]) mem[h_addr][7:0]  <= f_dat[f_rp][7:0];
      if (f_be[f_rp][1]) mem[h_addr][15:8] <= f_dat[f_rp][15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_pend   <= 1'b0;
      dat_valid <= 1'b0;
      dat_q     <= '0;
    end else if (ptr_take) begin
      pf_pend   <= ptr_in[B_RD];
      dat_valid <= 1'b0;
    end else if (consume) begin
      pf_pend   <= 1'b1;
      dat_valid <= 1'b0;
    end else if (pf_pend) begin
      pf_pend   <= 1'b0;
      dat_valid <= 1'b1;
      dat_q     <= len_word ? {{(16-LEN_W){1'b0}}, mem[cur_addr][LEN_W-1:0]} : mem[cur_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      last_wi  <= '0;
      last_b13 <= 1'b0;
    end else if (pop) begin
      last_wi <= h_wi;
      if (f_be[f_rp][1]) last_b13 <= f_dat[f_rp][13];
      if (h_wi == WI_W'(1)) begin
        if (f_be[f_rp][0]) len_q[7:0]  <= f_dat[f_rp][7:0];
        if (f_be[f_rp][1]) len_q[15:8] <= f_dat[f_rp][15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      chk_ok   <= 1'b0;
    end else begin
      chk_done <= tx_commit;
      if (tx_commit) chk_ok <= frame_ok;
    end
  end

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_cnt <= (FPW+1)'(FDEPTH));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_busy) |=> $stable({rd_q, ai_q, rx_q}));

  p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && dat_valid && ai_q && !ptr_we) |=> off_q == $past(off_q) + OFF_W'(2));

  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && !ptr_busy) |=> !dat_valid);

  p_valid_readdir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_valid) |-> rd_q);

  p_len_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && rx_q && off_q[OFF_W-1:1] == WI_W'(1)) |-> dat_out[15:LEN_W] == '0);

  p_chk_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_commit |=> chk_done);
endmodule

// File: tb/pkt_data_port_test.sv
module pkt_data_port_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        pnum_we = 0, ptr_we = 0, dat_we = 0, dat_re = 0, tx_commit = 0;
  logic [0:0]  pnum_in = '0, rx_pnum = '0;
  logic [15:0] ptr_in = '0, dat_in = '0;
  logic [1:0]  dat_be = 2'b11;
  logic [15:0] dat_out;
  logic        dat_valid, ptr_busy, chk_done, chk_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pkt_data_port uut (
    .clk(clk), .rst_n(rst_n), .pnum_we(pnum_we), .pnum_in(pnum_in), .rx_pnum(rx_pnum),
    .ptr_we(ptr_we), .ptr_in(ptr_in), .dat_we(dat_we), .dat_be(dat_be), .dat_in(dat_in),
    .dat_re(dat_re), .dat_out(dat_out), .dat_valid(dat_valid), .ptr_busy(ptr_busy),
    .tx_commit(tx_commit), .chk_done(chk_done), .chk_ok(chk_ok)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [15:0] pv(bit rx, bit ai, bit rd, int off);
    logic [10:0] o;
    o = off[10:0];
    return {rx, ai, rd, 2'b00, o};
  endfunction

  task automatic wait_idle();
    for (int g = 0; g < 20 && ptr_busy; g++) step();
  endtask

  task automatic set_slot(logic [0:0] s);
    pnum_we = 1; pnum_in = s; step(); pnum_we = 0;
  endtask

  task automatic put_ptr(logic [15:0] v);
    wait_idle();
    ptr_we = 1; ptr_in = v; step(); ptr_we = 0;
  endtask

  task automatic wr(logic [15:0] d, logic [1:0] be = 2'b11);
    dat_we = 1; dat_in = d; dat_be = be; step(); dat_we = 0; dat_be = 2'b11;
  endtask

  task automatic rd(output logic [15:0] d);
    for (int g = 0; g < 20 && !dat_valid; g++) step();
    d = dat_out;
    dat_re = 1; step(); dat_re = 0;
  endtask

  task automatic t_reset();
    check("R1 dat_valid", dat_valid, 0);
    check("R1 ptr_busy", ptr_busy, 0);
    check("R1 chk_done", chk_done, 0);
  endtask

  task automatic t_burst();
    logic [15:0] d;
    set_slot(0);
    put_ptr(pv(0, 1, 0, 'h10));
    for (int i = 0; i < 4; i++) wr(16'hA000 + 16'(i));
    wait_idle();
    put_ptr(pv(0, 1, 1, 'h10));
    for (int i = 0; i < 4; i++) begin
      rd(d);
      check("R3 R5 burst readback", d, 16'hA000 + 16'(i));
    end
  endtask

  task automatic t_busy_guard();
    logic [15:0] d;
    set_slot(1);
    put_ptr(pv(0, 1, 0, 'h200));
    wr(16'h5555);
    wait_idle();
    put_ptr(pv(0, 1, 0, 'h100));
    wr(16'h1111);
    check("R3 busy after write", ptr_busy, 1);
    ptr_we = 1; ptr_in = pv(0, 1, 0, 'h200); step(); ptr_we = 0;
    wr(16'h2222);
    wait_idle();
    check("R3 busy cleared", ptr_busy, 0);
    put_ptr(pv(0, 1, 1, 'h100));
    rd(d); check("R4 first word", d, 16'h1111);
    rd(d); check("R4 second word kept old pointer", d, 16'h2222);
    put_ptr(pv(0, 1, 1, 'h200));
    rd(d); check("R4 refused target untouched", d, 16'h5555);
  endtask

  task automatic t_no_advance();
    logic [15:0] d;
    set_slot(0);
    put_ptr(pv(0, 1, 0, 'h30));
    wr(16'hC0C0); wr(16'hC2C2);
    put_ptr(pv(0, 0, 0, 'h30));
    wr(16'h7777); wr(16'h8888);
    put_ptr(pv(0, 1, 1, 'h30));
    rd(d); check("R5 fixed offset last write wins", d, 16'h8888);
    rd(d); check("R5 neighbour untouched", d, 16'hC2C2);
    put_ptr(pv(0, 0, 1, 'h30));
    rd(d); check("R5 fixed read 1", d, 16'h8888);
    rd(d); check("R5 fixed read 2", d, 16'h8888);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    set_slot(0);
    put_ptr(pv(0, 1, 0, 0)); wr(16'h0BAD);
    set_slot(1);
    put_ptr(pv(0, 1, 0, 'h7FE));
    wr(16'hEEE1); wr(16'hEEE2);
    put_ptr(pv(0, 1, 1, 'h7FE));
    rd(d); check("R5 word at 2046", d, 16'hEEE1);
    rd(d); check("R5 wrapped to 0 same slot", d, 16'hEEE2);
    set_slot(0);
    put_ptr(pv(0, 1, 1, 0));
    rd(d); check("R5 other slot untouched by wrap", d, 16'h0BAD);
  endtask

  task automatic t_lanes();
    logic [15:0] d;
    set_slot(0);
    put_ptr(pv(0, 0, 0, 'h20));
    wr(16'h1234);
    wr(16'hAACD, 2'b01);
    put_ptr(pv(0, 0, 1, 'h20));
    rd(d); check("R7 low lane only", d, 16'h12CD);
    put_ptr(pv(0, 0, 0, 'h20));
    wr(16'hEF00, 2'b10);
    put_ptr(pv(0, 0, 1, 'h20));
    rd(d); check("R7 high lane only", d, 16'hEFCD);
  endtask

  task automatic t_rx_area();
    logic [15:0] d;
    set_slot(0);
    rx_pnum = 1'b1;
    put_ptr(pv(1, 1, 0, 2));
    wr(16'hF8AB);
    put_ptr(pv(1, 1, 1, 2));
    rd(d); check("R8 R2 rx length masked", d, 16'h00AB);
    set_slot(1);
    put_ptr(pv(0, 1, 1, 2));
    rd(d); check("R8 R2 tx view unmasked", d, 16'hF8AB);
    rx_pnum = 1'b0;
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    set_slot(0);
    put_ptr(pv(0, 1, 0, 'h40));
    wr(16'h4444); wr(16'h4646);
    put_ptr(pv(0, 1, 1, 'h40));
    dat_re = 1; step(); dat_re = 0;
    wr(16'h9999);
    check("R10 no queueing in read mode", ptr_busy, 0);
    rd(d); check("R10 early strobe and write ignored", d, 16'h4444);
    rd(d); check("R10 next word", d, 16'h4646);
  endtask

  task automatic t_prefetch();
    set_slot(0);
    put_ptr(pv(0, 1, 0, 'h60));
    wr(16'h6060); wr(16'h6262);
    put_ptr(pv(0, 1, 1, 'h60));
    check("R6 not valid after first edge", dat_valid, 0);
    step();
    check("R6 valid after second edge", dat_valid, 1);
    check("R6 first word", dat_out, 16'h6060);
    dat_re = 1; step(); dat_re = 0;
    check("R6 gap after consume", dat_valid, 0);
    step();
    check("R6 valid again", dat_valid, 1);
    check("R6 next word", dat_out, 16'h6262);
  endtask

  task automatic t_frame(string tag, int nbytes, int lenw, bit flip);
    logic [15:0] ctl;
    bit exp_ok;
    int last_off;
    set_slot(0);
    put_ptr(pv(0, 1, 0, 0));
    wr(16'h0000);
    wr(16'(lenw));
    for (int i = 0; i < nbytes / 2; i++) wr(16'h0101 * 16'(i));
    ctl = (nbytes % 2 == 1) ? 16'h2000 | 16'h005A : 16'h0000;
    if (flip) ctl = ctl ^ 16'h2000;
    wr(ctl);
    wait_idle();
    last_off = 4 + 2 * (nbytes / 2);
    exp_ok = lenw >= 66 && lenw <= 2048 && last_off == ((lenw - 2) & ~1)
             && ctl[13] == lenw[0];
    tx_commit = 1; step(); tx_commit = 0;
    check({"R9 done pulse ", tag}, chk_done, 1);
    check({"R9 verdict ", tag}, chk_ok, exp_ok);
    step();
    check({"R9 pulse ends ", tag}, chk_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_burst();
    t_busy_guard();
    t_no_advance();
    t_wrap();
    t_lanes();
    t_rx_area();
    t_ignored();
    t_prefetch();
    t_frame("even min", 60, 66, 0);
    t_frame("odd", 61, 67, 0);
    t_frame("short", 58, 64, 0);
    t_frame("odd flag missing", 61, 67, 1);
    t_frame("odd flag spurious", 60, 66, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule